// File: doc/BRIEF.md
# I2C Bit-Rate Selector and Quarter-Bit Tick Generator

This block holds the speed setting of a downstream I2C display data channel and turns it into timing for an I2C master engine. The host writes an 8-bit mask in which each bit stands for one bus speed. The block keeps only the bits that name speeds it can run. Of those, it adopts the slowest. A write that leaves no supported speed is dropped, and the speed in use stays as it was. A read returns the single bit of the speed now in use.

Until the first accepted write, a strap input picks the speed. Low selects 50 kbit/s and high selects 10 kbit/s. From the reference clock the block makes four evenly spaced ticks per I2C bit, each tagged with its quarter-bit phase. A new divisor is taken only at the end of a bit, so a speed change never cuts a bit short.

The host-side read/write pins and the strap are plain control pins. There is no data stream, so there is no handshake or back-pressure. A write strobe is always accepted in the cycle it is high.

Top module: `i2c_rate_sel`

## Requirements
- R1: The speed bits are bit0 = 1 kbit/s, bit1 = 3 kbit/s, bit2 = 10 kbit/s, bit3 = 100 kbit/s and bit7 = 50 kbit/s. Bits 4 (400 kbit/s), 5 (1 Mbit/s) and 6 (reserved) are not supported. The readback `cfg_rdata` always has exactly one bit set, and that bit is one of 0, 1, 2, 3 or 7.
- R2: Before any accepted write, the speed follows `strap_slow`: low gives 50 kbit/s (readback 0x80) and high gives 10 kbit/s (readback 0x04). This also holds right after reset.
- R3: An accepted write selects the slowest speed in (mask AND 0x8F), in the order 1 < 3 < 10 < 50 < 100 kbit/s. Writing 0xFF gives 0x01, 0x0C gives 0x04, 0x88 gives 0x80 and 0x0A gives 0x02.
- R4: A write whose mask AND 0x8F is zero has no effect (for example 0x30, 0x40, 0x70 or 0x00). The readback and the tick spacing stay as they were.
- R5: The readback shows a newly selected speed in the clock cycle after the cycle in which the write strobe is sampled high.
- R6: After the first accepted write, changes on `strap_slow` have no effect on the speed.
- R7: Ticks come every round(CLK_HZ / (4 × rate)) clock cycles. `tick_phase` steps 0, 1, 2, 3 and wraps on each tick, so four ticks make one bit.
- R8: A speed change takes effect only after the tick with phase 3. The remaining ticks of the current bit keep the old spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_slow | input | 1 | Default speed select: 0 = 50 kbit/s, 1 = 10 kbit/s |
| cfg_wr | input | 1 | Write strobe for the speed mask |
| cfg_wdata | input | 8 | Speed mask written by the host |
| cfg_rdata | output | 8 | One-hot bit of the speed in use |
| qtick | output | 1 | One-cycle quarter-bit tick |
| tick_phase | output | 2 | Quarter index of the current tick |

## Verification
The bench builds the block with CLK_HZ set to 400 000 instead of 27 MHz. This scales the quarter-bit divisors to 100, 33, 10, 2 and 1 cycles, so every speed, including the slowest, can be timed tick by tick in a short run. The 100 kbit/s divisor of one cycle also tests the back-to-back tick corner. A switch from 10 to 1 kbit/s in the middle of a bit shows where the divisor reload happens.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

  typedef enum logic [2:0] {
    SPD_1K   = 3'd0,
    SPD_3K   = 3'd1,
    SPD_10K  = 3'd2,
    SPD_50K  = 3'd3,
    SPD_100K = 3'd4
  } spd_e;

  localparam int NUM_SPD = 5;
  localparam logic [7:0] CAP_MASK = 8'h8F;

  function automatic int spd_rate(input int idx);
    case (idx)
      0:       return 1000;
      1:       return 3000;
      2:       return 10000;
      3:       return 50000;
      default: return 100000;
    endcase
  endfunction

  function automatic logic [2:0] spd_bitpos(input spd_e s);
    case (s)
      SPD_1K:   return 3'd0;
      SPD_3K:   return 3'd1;
      SPD_10K:  return 3'd2;
      SPD_50K:  return 3'd7;
      default:  return 3'd3;
    endcase
  endfunction

  function automatic spd_e spd_slowest(input logic [7:0] m);
    if (m[0])      return SPD_1K;
    else if (m[1]) return SPD_3K;
    else if (m[2]) return SPD_10K;
    else if (m[7]) return SPD_50K;
    else           return SPD_100K;
  endfunction

endpackage

// File: rtl/i2c_speed_reg.sv
module i2c_speed_reg
  import i2c_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_slow,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output spd_e       spd_now
);

  logic [7:0] masked;
  logic       hit;
  logic       written_q;
  spd_e       code_q;

  assign masked = cfg_wdata & CAP_MASK;
  assign hit    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= 1'b0;
      code_q    <= SPD_50K;
    end else if (cfg_wr && hit) begin
      written_q <= 1'b1;
      code_q    <= spd_slowest(masked);
    end
  end

  always_comb begin
    if (written_q)       spd_now = code_q;
    else if (strap_slow) spd_now = SPD_10K;
    else                 spd_now = SPD_50K;
  end

  assign cfg_rdata = 8'h01 << spd_bitpos(spd_now);

  assert_readback_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cfg_rdata) == 1) && ((cfg_rdata & ~CAP_MASK) == 8'h00));

  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[0]) |=> (cfg_rdata == 8'h01));

  assert_empty_mask_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !hit && written_q) |=> $stable(cfg_rdata));

  assert_strap_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (written_q && !cfg_wr) |=> $stable(cfg_rdata));

endmodule

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen
  import i2c_rate_pkg::*;
#(
  parameter int CLK_HZ = 27_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  spd_e       spd_req,
  output logic       qtick,
  output logic [1:0] tick_phase
);

  localparam int MAX_DIV = (CLK_HZ + 2 * 1000) / (4 * 1000);
  localparam int DIV_W   = $clog2(MAX_DIV + 1) + 1;

  logic [DIV_W-1:0] div_tab [NUM_SPD];

  for (genvar g = 0; g < NUM_SPD; g++) begin : g_div
    localparam int RATE = spd_rate(g);
    localparam int DIVV = (CLK_HZ + 2 * RATE) / (4 * RATE);
    assign div_tab[g] = DIV_W'((DIVV < 1) ? 1 : DIVV);
  end

  logic [DIV_W-1:0] req_div;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       q;
  logic             primed;

  always_comb begin
    case (spd_req)
      SPD_1K:  req_div = div_tab[0];
      SPD_3K:  req_div = div_tab[1];
      SPD_10K: req_div = div_tab[2];
      SPD_50K: req_div = div_tab[3];
      default: req_div = div_tab[4];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      act_div <= '0;
      cnt     <= '0;
      q       <= 2'd0;
    end else if (!primed) begin
      primed  <= 1'b1;
      act_div <= req_div;
      cnt     <= req_div - 1'b1;
      q       <= 2'd0;
    end else if (cnt == '0) begin
      q <= q + 2'd1;
      if (q == 2'd3) begin
        act_div <= req_div;
        cnt     <= req_div - 1'b1;
      end else begin
        cnt <= act_div - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign qtick      = primed && (cnt == '0);
  assign tick_phase = q;

  assert_phase_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> (tick_phase == $past(tick_phase) + 2'd1));

  assert_phase_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !qtick) |=> $stable(tick_phase));

  assert_div_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (qtick && tick_phase != 2'd3) |=> $stable(act_div));

endmodule

// File: rtl/i2c_rate_sel.sv
module i2c_rate_sel
  import i2c_rate_pkg::*;
#(
  parameter int CLK_HZ = 27_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_slow,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       qtick,
  output logic [1:0] tick_phase
);

  spd_e spd_now;

  i2c_speed_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_slow (strap_slow),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .spd_now    (spd_now)
  );

  i2c_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .spd_req    (spd_now),
    .qtick      (qtick),
    .tick_phase (tick_phase)
  );

endmodule

// File: tb/tb_i2c_rate_sel.sv
module tb_i2c_rate_sel;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 400_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_slow = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       qtick;
  logic [1:0] tick_phase;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rate_sel #(.CLK_HZ(TB_CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .strap_slow(strap_slow),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .qtick(qtick), .tick_phase(tick_phase)
  );

  function automatic int exp_div(input int rate);
    return (TB_CLK_HZ + 2 * rate) / (4 * rate);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic next_tick(output int dt, output int ph);
    dt = 0;
    do begin
      @(negedge clk);
      cfg_wr = 1'b0;
      dt++;
    end while (!qtick);
    ph = tick_phase;
  endtask

  task automatic sync_phase3();
    int dt, ph;
    do next_tick(dt, ph); while (ph != 3);
  endtask

  task automatic do_write(input logic [7:0] m);
    cfg_wr = 1'b1;
    cfg_wdata = m;
  endtask

  task automatic write_and_read(input logic [7:0] m, input int exp, input string req);
    do_write(m);
    @(negedge clk);
    cfg_wr = 1'b0;
    check(req, cfg_rdata, exp);
  endtask

  task automatic check_bit_spacing(input int rate, input string req);
    int dt, ph;
    sync_phase3();
    for (int i = 0; i < 4; i++) begin
      next_tick(dt, ph);
      check({req, " spacing"}, dt, exp_div(rate));
      check({req, " phase"}, ph, i);
    end
  endtask

  task automatic t_reset_default();
    check("R2 reset strap low", cfg_rdata, 8'h80);
    check_bit_spacing(50000, "R7 50k");
  endtask

  task automatic t_strap_follow();
    strap_slow = 1'b1;
    @(negedge clk);
    check("R2 strap high", cfg_rdata, 8'h04);
    check_bit_spacing(10000, "R7 10k");
  endtask

  task automatic t_select();
    write_and_read(8'hFF, 8'h01, "R3 mask FF");
    write_and_read(8'h0C, 8'h04, "R3 mask 0C");
    write_and_read(8'h88, 8'h80, "R3 mask 88");
    write_and_read(8'h0A, 8'h02, "R3 mask 0A");
    check_bit_spacing(3000, "R7 3k");
    write_and_read(8'h08, 8'h08, "R1 100k bit3");
    write_and_read(8'h80, 8'h80, "R1 50k bit7");
    write_and_read(8'hF8, 8'h80, "R5 readback next cycle");
  endtask

  task automatic t_ignore();
    write_and_read(8'h08, 8'h08, "R4 setup 100k");
    write_and_read(8'h30, 8'h08, "R4 mask 30");
    write_and_read(8'h40, 8'h08, "R4 mask 40");
    write_and_read(8'h70, 8'h08, "R4 mask 70");
    write_and_read(8'h00, 8'h08, "R4 mask 00");
    check_bit_spacing(100000, "R4 R7 100k kept");
  endtask

  task automatic t_strap_locked();
    strap_slow = 1'b0;
    @(negedge clk);
    check("R6 strap low ignored", cfg_rdata, 8'h08);
    strap_slow = 1'b1;
    @(negedge clk);
    check("R6 strap high ignored", cfg_rdata, 8'h08);
  endtask

  task automatic t_boundary();
    int dt, ph;
    write_and_read(8'h04, 8'h04, "R8 setup 10k");
    sync_phase3();
    next_tick(dt, ph);
    check("R8 pre phase", ph, 0);
    do_write(8'h01);
    for (int i = 1; i < 4; i++) begin
      next_tick(dt, ph);
      check("R8 old spacing kept", dt, exp_div(10000));
      check("R8 phase", ph, i);
    end
    check("R8 readback switched", cfg_rdata, 8'h01);
    next_tick(dt, ph);
    check("R8 new spacing after boundary", dt, exp_div(1000));
    check("R8 phase wrap", ph, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_default();
    t_strap_follow();
    t_select();
    t_ignore();
    t_strap_locked();
    t_boundary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule